// File: doc/BRIEF.md
# Cascadable Decimal Digit Counter

This block is one decimal digit of a synchronous counter. On each rising clock edge it steps its 4-bit value through the ten decimal states 0 to 9 and back to 0, loads a 4-bit value in place of counting, or holds. An active-low clear input forces the value to 0 at once, with no clock edge needed.

Counting needs two enables. The first, `enable_p`, only gates this digit's own stepping. The second, `enable_t`, also gates the terminal-count flag `tc` through combinational logic, with no register in that path. This lets digits be chained: each digit's `tc` drives `enable_t` of the next, more significant digit, and all digits share the clock and `enable_p`. The carry then passes forward as a one-cycle pulse and never goes through any digit's next-state logic.

Top module: `bcdc_digit`

## Requirements
- R1: While `clear_n` is 0, `count` is 0 at once, without waiting for a clock edge and whatever the levels of `clk`, `load_n`, `enable_p` and `enable_t`; `tc` is then 0 too.
- R2: With `load_n` = 1 and both `enable_p` and `enable_t` at 1, each rising clock edge moves `count` from n to n+1 for n in 0..8, and from 9 to 0.
- R3: With `load_n` = 0, the next rising clock edge copies `data_in` into `count`, whatever the levels of `enable_p` and `enable_t`.
- R4: With `load_n` = 1 and either enable at 0, `count` keeps its value across rising clock edges.
- R5: `tc` is 1 exactly when `enable_t` is 1 and `count` equals 9 (binary 1001). It follows `enable_t` in the same cycle, without waiting for a clock edge.
- R6: A loaded value from 10 to 15 is held as loaded. A counting step from any of these values gives 0, and `tc` stays 0 while the digit holds such a value.
- R7: When digits are chained (each `tc` drives the next digit's `enable_t`, and `enable_p` and `clk` are shared), the digits together count in decimal from 000 to 999 and then wrap to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all changes except clear happen on its rising edge |
| clear_n | input | 1 | Active-low asynchronous clear of the count |
| load_n | input | 1 | Active-low synchronous load of `data_in`; overrides both enables |
| data_in | input | 4 | Value to load |
| enable_p | input | 1 | Count enable that gates stepping only |
| enable_t | input | 1 | Count enable that also gates `tc`; the carry input of a chain |
| count | output | 4 | Current digit value, binary coded |
| tc | output | 1 | Terminal count: `enable_t` AND (`count` == 9) |

## Verification
Load, step and hold show on `count` one rising edge after the inputs are applied. `tc` depends on `enable_t` combinationally, so it answers within the same cycle. Clear answers as soon as `clear_n` falls. The bench applies inputs just after each falling edge and updates its reference model at the rising edge. It compares every digit and flag at the following falling edge, which is the first point where a registered result is due and the inputs are still stable. The clear test drops `clear_n` in the middle of a cycle and compares 1 ns later, before any clock edge, which shows that the clear does not wait for the clock.

// File: rtl/bcdc_pkg.sv
// Package bcdc_pkg
// Shared types for the decimal digit counter: the operation that a digit
// carries out on the next rising edge.
package bcdc_pkg;

    // Operation chosen for the next rising clock edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2
    } digit_op_t;

endpackage

// File: rtl/bcdc_mode_dec.sv
// Module bcdc_mode_dec
// Turns the load and enable pins into one operation code. The load request
// takes priority over both enables, and a step needs both enables high.
// Assumes all inputs are synchronous to the digit clock.
module bcdc_mode_dec
    import bcdc_pkg::*;
(
    input  logic      load_n,
    input  logic      enable_p,
    input  logic      enable_t,
    output digit_op_t op
);

    // Priority decode: load first, then step, otherwise hold
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (enable_p && enable_t)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/bcdc_step.sv
// Module bcdc_step
// Works out the next digit value from the operation code. A step from LAST,
// or from any code above it, wraps to zero. When the modulus fills the
// whole field, natural overflow does the wrap and no comparator is built.
// Assumes LAST < 2**DIGIT_W.
module bcdc_step
    import bcdc_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter int LAST    = 9
) (
    input  digit_op_t            op,
    input  logic [DIGIT_W-1:0]   cur,
    input  logic [DIGIT_W-1:0]   data_in,
    output logic [DIGIT_W-1:0]   nxt
);

    localparam int                 FULL_SPAN = (1 << DIGIT_W);
    localparam logic [DIGIT_W-1:0] LAST_V    = DIGIT_W'(LAST);

    logic [DIGIT_W-1:0] incr;

    generate
        if (LAST + 1 == FULL_SPAN) begin : g_natural
            // Whole field used: binary overflow wraps to zero
            always_comb incr = cur + 1'b1;
        end else begin : g_bounded
            // Partial field: LAST and any code above it wrap to zero
            always_comb incr = (cur >= LAST_V) ? '0 : cur + 1'b1;
        end
    endgenerate

    // Pick the next value for the operation code
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = data_in;
            OP_STEP: nxt = incr;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/bcdc_carry.sv
// Module bcdc_carry
// Terminal-count flag. It comes straight from the carry-in enable, so a chain
// of digits passes its carry forward with no register in the path.
// Assumes cur is a registered value.
module bcdc_carry #(
    parameter int DIGIT_W = 4,
    parameter int LAST    = 9
) (
    input  logic [DIGIT_W-1:0] cur,
    input  logic               enable_t,
    output logic               tc
);

    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST);

    // Flag the last state, gated by the carry-in enable
    always_comb tc = enable_t && (cur == LAST_V);

endmodule

// File: rtl/bcdc_digit.sv
// Module bcdc_digit
// One decimal digit of a cascadable counter with synchronous load, two count
// enables, and an active-low clear that acts at once. To chain digits, feed
// each digit's tc into the next digit's enable_t and share clk and enable_p.
// Assumes clear_n is released away from a clock edge.
module bcdc_digit
    import bcdc_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter int LAST    = 9
) (
    input  logic               clk,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic [DIGIT_W-1:0] data_in,
    input  logic               enable_p,
    input  logic               enable_t,
    output logic [DIGIT_W-1:0] count,
    output logic               tc
);

    digit_op_t          op;
    logic [DIGIT_W-1:0] nxt;
    logic [DIGIT_W-1:0] value_q;

    bcdc_mode_dec u_dec (
        .load_n   (load_n),
        .enable_p (enable_p),
        .enable_t (enable_t),
        .op       (op)
    );

    bcdc_step #(.DIGIT_W(DIGIT_W), .LAST(LAST)) u_step (
        .op      (op),
        .cur     (value_q),
        .data_in (data_in),
        .nxt     (nxt)
    );

    bcdc_carry #(.DIGIT_W(DIGIT_W), .LAST(LAST)) u_carry (
        .cur      (value_q),
        .enable_t (enable_t),
        .tc       (tc)
    );

    // Digit register: cleared at once by clear_n, otherwise updated on the clock
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            value_q <= '0;
        else
            value_q <= nxt;
    end

    assign count = value_q;

endmodule

// File: rtl/bcdc_digit_chk.sv
// Module bcdc_digit_chk
// Property checker for bcdc_digit, watching only its ports. Bound to every
// instance of the digit.
module bcdc_digit_chk #(
    parameter int DIGIT_W = 4,
    parameter int LAST    = 9
) (
    input logic               clk,
    input logic               clear_n,
    input logic               load_n,
    input logic [DIGIT_W-1:0] data_in,
    input logic               enable_p,
    input logic               enable_t,
    input logic [DIGIT_W-1:0] count,
    input logic               tc
);

    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST);

    AST_CLEAR_ZERO: assert property (@(posedge clk) !clear_n |-> (count == '0 && !tc)); // R1

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && enable_p && enable_t) |=>
        (count == (($past(count) >= LAST_V) ? '0 : $past(count) + 1'b1))); // R2

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (count == $past(data_in))); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(enable_p && enable_t)) |=> $stable(count)); // R4

    AST_TC_GATED: assert property (@(posedge clk) disable iff (!clear_n)
        !enable_t |-> !tc); // R5

    AST_TC_LAST_ONLY: assert property (@(posedge clk) disable iff (!clear_n)
        tc |-> (count == LAST_V)); // R6

endmodule

bind bcdc_digit bcdc_digit_chk #(.DIGIT_W(DIGIT_W), .LAST(LAST)) u_chk (
    .clk      (clk),
    .clear_n  (clear_n),
    .load_n   (load_n),
    .data_in  (data_in),
    .enable_p (enable_p),
    .enable_t (enable_t),
    .count    (count),
    .tc       (tc)
);

// File: tb/sim_bcdc_digit.sv
// Bench: three chained digits, compared on every clock with a behavioural model.
module sim_bcdc_digit;

    localparam int N = 3;

    logic       clk = 1'b0;
    logic       clear_n = 1'b1;
    logic       load_n = 1'b1;
    logic       en_p = 1'b0;
    logic       en_t0 = 1'b0;
    logic [3:0] ld [N];
    logic [3:0] q  [N];
    logic       tcv[N];
    logic       et [N];

    int m_d[N];
    int ref_int;
    bit sweep_on;
    int ntests = 0;
    int nfail  = 0;

    always #5 clk = ~clk;

    assign et[0] = en_t0;

    for (genvar i = 0; i < N; i++) begin : g_dig
        if (i > 0) begin : g_link
            assign et[i] = tcv[i-1];
        end
        bcdc_digit u0 (
            .clk      (clk),
            .clear_n  (clear_n),
            .load_n   (load_n),
            .data_in  (ld[i]),
            .enable_p (en_p),
            .enable_t (et[i]),
            .count    (q[i]),
            .tc       (tcv[i])
        );
    end

    function automatic bit model_tc(input int i);
        bit e = (en_t0 == 1'b1);
        for (int k = 0; k < i; k++) e = e && (m_d[k] == 9);
        return e && (m_d[i] == 9);
    endfunction

    task automatic compare(input string req);
        string act = "", exp = "";
        bit bad = 0;
        for (int i = N - 1; i >= 0; i--) begin
            act = {act, $sformatf("%0d/%0b ", q[i], tcv[i])};
            exp = {exp, $sformatf("%0d/%0b ", m_d[i], model_tc(i))};
            if (q[i] !== 4'(m_d[i]) || tcv[i] !== model_tc(i)) bad = 1;
        end
        ntests++;
        if (bad) begin
            nfail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
        if (sweep_on) begin
            int dec = q[2] * 100 + q[1] * 10 + q[0];
            ntests++;
            if (dec != ref_int) begin
                nfail++;
                $display("FAIL R7 actual=%0d expected=%0d", dec, ref_int);
            end
        end
    endtask

    task automatic tick(input string req);
        bit c[N];
        @(posedge clk);
        for (int i = 0; i < N; i++) c[i] = (i == 0) ? en_t0 : model_tc(i - 1);
        for (int i = 0; i < N; i++) begin
            if (!clear_n) m_d[i] = 0;
            else if (!load_n) m_d[i] = int'(ld[i]);
            else if (en_p && c[i]) m_d[i] = (m_d[i] >= 9) ? 0 : m_d[i] + 1;
        end
        if (sweep_on && clear_n && load_n && en_p && en_t0) ref_int = (ref_int + 1) % 1000;
        @(negedge clk);
        #1;
        compare(req);
    endtask

    task automatic set_ld(input int a2, input int a1, input int a0);
        ld[2] = 4'(a2); ld[1] = 4'(a1); ld[0] = 4'(a0);
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        set_ld(0, 0, 0);
        for (int i = 0; i < N; i++) m_d[i] = 0;
        #2 clear_n = 1'b0;
        #1 compare("R1 reset");
        @(negedge clk); #1 clear_n = 1'b1;

        // R2 counting with both enables, carry into digit 1
        en_p = 1; en_t0 = 1;
        for (int k = 0; k < 12; k++) tick("R2");

        // R3 load with enables low, then with enables high
        load_n = 0; en_p = 0; en_t0 = 0; set_ld(2, 7, 3);
        tick("R3");
        en_p = 1; en_t0 = 1; set_ld(9, 9, 9);
        tick("R3");
        // R5 at 999 all flags high; R7 wrap to 000
        load_n = 1;
        #1 compare("R5");
        tick("R7");

        // R4 hold with either enable low
        load_n = 0; set_ld(5, 5, 9); tick("R3");
        load_n = 1; en_p = 0; en_t0 = 1;
        for (int k = 0; k < 3; k++) tick("R4");
        en_p = 1; en_t0 = 0;
        for (int k = 0; k < 3; k++) tick("R4");
        // R5 flag follows enable_t in the same cycle
        en_p = 0; en_t0 = 1;
        #1 compare("R5");
        en_t0 = 0;
        #1 compare("R5");

        // R6 out-of-range loads
        load_n = 0; set_ld(0, 4, 12); tick("R6");
        load_n = 1; en_p = 0; en_t0 = 1;
        tick("R6");
        en_p = 1;
        tick("R6");
        tick("R6");
        load_n = 0; set_ld(15, 9, 15); tick("R6");
        load_n = 1; tick("R6");

        // R7 full sweep from 000 through the wrap
        load_n = 0; set_ld(0, 0, 0); tick("R3");
        load_n = 1; ref_int = 0; sweep_on = 1;
        for (int k = 0; k < 1005; k++) tick("R7");
        sweep_on = 0;

        // R1 clear in the middle of a cycle, held across an edge
        #1 clear_n = 0;
        for (int i = 0; i < N; i++) m_d[i] = 0;
        #1 compare("R1 mid-cycle");
        load_n = 0; set_ld(8, 8, 8);
        tick("R1");
        clear_n = 1; load_n = 1;
        tick("R2");

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule